// File: doc/BRIEF.md
# Register Interlock Hazard Detector

This combinational unit decides, in the same cycle, whether the instruction now in the decode stage of a five-stage load/store pipeline must be held back. The pipeline has no forwarding paths. The unit reads the raw instruction words held in decode, execute, memory access and write-back. For each later stage it works out which register, if any, that instruction will write. For the decode instruction it works out which of its two source fields are really read. It raises `stall` when a source that is really read names a register that a later stage is still going to write.

Instruction words are 32 bits. The opcode sits in bits 31:26, the first source in 25:21 and the second source in 20:16. The register-register destination sits in 15:11. Immediate forms use the bits below these fields. Opcode values are parameters. The defaults are:

| Class | Opcode |
|---|---|
| register-register ALU | 0x00 |
| jump | 0x02 |
| jump-and-link | 0x03 |
| branch-if-zero | 0x04 |
| jump-register | 0x06 |
| jump-and-link-register | 0x07 |
| immediate ALU | 0x08 to 0x0F |
| load | 0x23 |
| store | 0x2B |

Any other opcode neither reads nor writes a register.

Top module: `hazard_interlock`

## Requirements
- R1: When the decode instruction reads its first source (bits 25:21), `stall` is 1 in the same cycle if any of execute, memory or write-back writes that register. This source is read by register-register ALU, immediate ALU, load, store, branch-if-zero, jump-register and jump-and-link-register.
- R2: The second source (bits 20:16) of the decode instruction causes a stall on a match only for register-register ALU (opcode 0x00) and store (0x2B).
- R3: The register written by a later-stage instruction is bits 15:11 for register-register ALU and bits 20:16 for immediate ALU and load. It is register 31 for jump-and-link (0x03) and jump-and-link-register (0x07), whatever their other bits hold.
- R4: A register-register ALU, immediate ALU or load whose destination is register 0 writes nothing. A decode source naming register 0 therefore never stalls.
- R5: Store, branch-if-zero, jump, jump-register and unassigned opcodes in a later stage never cause a stall. This covers a store followed by a load from the same address.
- R6: A jump (0x02) or jump-and-link (0x03) in decode reads no register and never stalls.
- R7: A match on bits 20:16 of an immediate ALU, load, branch-if-zero or jump-register in decode does not stall.
- R8: The all-zero word used as a pipeline bubble never stalls, in any stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_d | input | 32 | Instruction word in the decode stage |
| insn_e | input | 32 | Instruction word in the execute stage |
| insn_m | input | 32 | Instruction word in the memory access stage |
| insn_w | input | 32 | Instruction word in the write-back stage |
| stall | output | 1 | Hold decode and insert a bubble this cycle |

## Verification
The hardest case to reach is a field match that must be ignored. Two conditions make this so: the decode instruction does not read the matching field, or the later instruction writes a register other than the one its bit fields suggest, as with the implicit link register or a write to register 0. Uniform random words almost never line up register fields. The stimulus therefore draws register numbers from a pool of four small values plus 31, and draws opcodes from the assigned set plus one unassigned value. This makes such near-miss quadruples common. Directed vectors then pin each ignored-match case.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
   typedef enum logic [3:0] {
      CL_NONE,
      CL_ALU,
      CL_ALUI,
      CL_LOAD,
      CL_STORE,
      CL_BRZ,
      CL_JUMP,
      CL_JLINK,
      CL_JREG,
      CL_JLREG
   } insn_class_e;

   localparam logic [5:0] DEF_OP_RTYPE   = 6'h00;
   localparam logic [5:0] DEF_OP_JUMP    = 6'h02;
   localparam logic [5:0] DEF_OP_JLINK   = 6'h03;
   localparam logic [5:0] DEF_OP_BRZ     = 6'h04;
   localparam logic [5:0] DEF_OP_JREG    = 6'h06;
   localparam logic [5:0] DEF_OP_JLREG   = 6'h07;
   localparam logic [5:0] DEF_OP_ALUI_LO = 6'h08;
   localparam logic [5:0] DEF_OP_ALUI_HI = 6'h0F;
   localparam logic [5:0] DEF_OP_LOAD    = 6'h23;
   localparam logic [5:0] DEF_OP_STORE   = 6'h2B;
endpackage

// File: rtl/hzd_classify.sv
module hzd_classify
   import hzd_pkg::*;
#(
   parameter int OP_W = 6,
   parameter logic [OP_W-1:0] OP_RTYPE   = DEF_OP_RTYPE,
   parameter logic [OP_W-1:0] OP_JUMP    = DEF_OP_JUMP,
   parameter logic [OP_W-1:0] OP_JLINK   = DEF_OP_JLINK,
   parameter logic [OP_W-1:0] OP_BRZ     = DEF_OP_BRZ,
   parameter logic [OP_W-1:0] OP_JREG    = DEF_OP_JREG,
   parameter logic [OP_W-1:0] OP_JLREG   = DEF_OP_JLREG,
   parameter logic [OP_W-1:0] OP_ALUI_LO = DEF_OP_ALUI_LO,
   parameter logic [OP_W-1:0] OP_ALUI_HI = DEF_OP_ALUI_HI,
   parameter logic [OP_W-1:0] OP_LOAD    = DEF_OP_LOAD,
   parameter logic [OP_W-1:0] OP_STORE   = DEF_OP_STORE
) (
   input  logic [OP_W-1:0] op_i,
   output insn_class_e     cls_o
);
   always_comb begin
      cls_o = CL_NONE;
      if (op_i == OP_RTYPE)                              cls_o = CL_ALU;
      else if (op_i >= OP_ALUI_LO && op_i <= OP_ALUI_HI) cls_o = CL_ALUI;
      else if (op_i == OP_LOAD)                          cls_o = CL_LOAD;
      else if (op_i == OP_STORE)                         cls_o = CL_STORE;
      else if (op_i == OP_BRZ)                           cls_o = CL_BRZ;
      else if (op_i == OP_JUMP)                          cls_o = CL_JUMP;
      else if (op_i == OP_JLINK)                         cls_o = CL_JLINK;
      else if (op_i == OP_JREG)                          cls_o = CL_JREG;
      else if (op_i == OP_JLREG)                         cls_o = CL_JLREG;
   end
endmodule

// File: rtl/hzd_dest_dec.sv
module hzd_dest_dec
   import hzd_pkg::*;
#(
   parameter int REG_AW   = 5,
   parameter int LINK_REG = 31
) (
   input  insn_class_e       cls_i,
   input  logic [REG_AW-1:0] rt_i,
   input  logic [REG_AW-1:0] rd_i,
   output logic              we_o,
   output logic [REG_AW-1:0] ws_o
);
   localparam logic [REG_AW-1:0] LINK_IDX = REG_AW'(LINK_REG);

   always_comb begin
      ws_o = '0;
      we_o = 1'b0;
      unique case (cls_i)
         CL_ALU:            begin ws_o = rd_i;     we_o = (rd_i != '0); end
         CL_ALUI, CL_LOAD:  begin ws_o = rt_i;     we_o = (rt_i != '0); end
         CL_JLINK, CL_JLREG: begin ws_o = LINK_IDX; we_o = 1'b1; end
         default:           begin ws_o = '0;       we_o = 1'b0; end
      endcase
   end
endmodule

// File: rtl/hzd_src_dec.sv
module hzd_src_dec
   import hzd_pkg::*;
(
   input  insn_class_e cls_i,
   output logic        re1_o,
   output logic        re2_o
);
   always_comb begin
      unique case (cls_i)
         CL_ALU, CL_STORE: re1_o = 1'b1;
         CL_ALUI, CL_LOAD, CL_BRZ, CL_JREG, CL_JLREG: re1_o = 1'b1;
         default: re1_o = 1'b0;
      endcase
      re2_o = (cls_i == CL_ALU) || (cls_i == CL_STORE);
   end
endmodule

// File: rtl/hzd_cmp.sv
module hzd_cmp #(
   parameter int REG_AW = 5
) (
   input  logic [REG_AW-1:0] src_i,
   input  logic              re_i,
   input  logic [REG_AW-1:0] ws_i,
   input  logic              we_i,
   output logic              hit_o
);
   assign hit_o = re_i && we_i && (src_i == ws_i);
endmodule

// File: rtl/hazard_interlock.sv
module hazard_interlock
   import hzd_pkg::*;
#(
   parameter int INSN_W   = 32,
   parameter int OP_W     = 6,
   parameter int REG_AW   = 5,
   parameter int LINK_REG = 31,
   parameter logic [OP_W-1:0] OP_RTYPE   = DEF_OP_RTYPE,
   parameter logic [OP_W-1:0] OP_JUMP    = DEF_OP_JUMP,
   parameter logic [OP_W-1:0] OP_JLINK   = DEF_OP_JLINK,
   parameter logic [OP_W-1:0] OP_BRZ     = DEF_OP_BRZ,
   parameter logic [OP_W-1:0] OP_JREG    = DEF_OP_JREG,
   parameter logic [OP_W-1:0] OP_JLREG   = DEF_OP_JLREG,
   parameter logic [OP_W-1:0] OP_ALUI_LO = DEF_OP_ALUI_LO,
   parameter logic [OP_W-1:0] OP_ALUI_HI = DEF_OP_ALUI_HI,
   parameter logic [OP_W-1:0] OP_LOAD    = DEF_OP_LOAD,
   parameter logic [OP_W-1:0] OP_STORE   = DEF_OP_STORE
) (
   input  logic [INSN_W-1:0] insn_d,
   input  logic [INSN_W-1:0] insn_e,
   input  logic [INSN_W-1:0] insn_m,
   input  logic [INSN_W-1:0] insn_w,
   output logic              stall
);
   localparam int NST    = 4;
   localparam int NLATER = NST - 1;
   localparam int OP_LSB = INSN_W - OP_W;
   localparam int RS_LSB = OP_LSB - REG_AW;
   localparam int RT_LSB = RS_LSB - REG_AW;
   localparam int RD_LSB = RT_LSB - REG_AW;

   if (RD_LSB < 0) begin : g_bad_width
      $error("instruction word too narrow for opcode and three register fields");
   end
   if (LINK_REG >= (1 << REG_AW) || LINK_REG < 1) begin : g_bad_link
      $error("link register index out of range");
   end
   if (OP_ALUI_LO > OP_ALUI_HI) begin : g_bad_alui
      $error("immediate ALU opcode range is empty");
   end

   logic [INSN_W-1:0] insn_a [NST];
   insn_class_e       cls_a  [NST];
   logic [NLATER-1:0] hit_rs;
   logic [NLATER-1:0] hit_rt;
   logic              re1_d;
   logic              re2_d;

   assign insn_a[0] = insn_d;
   assign insn_a[1] = insn_e;
   assign insn_a[2] = insn_m;
   assign insn_a[3] = insn_w;

   for (genvar s = 0; s < NST; s++) begin : g_cls
      hzd_classify #(
         .OP_W(OP_W), .OP_RTYPE(OP_RTYPE), .OP_JUMP(OP_JUMP), .OP_JLINK(OP_JLINK),
         .OP_BRZ(OP_BRZ), .OP_JREG(OP_JREG), .OP_JLREG(OP_JLREG),
         .OP_ALUI_LO(OP_ALUI_LO), .OP_ALUI_HI(OP_ALUI_HI),
         .OP_LOAD(OP_LOAD), .OP_STORE(OP_STORE)
      ) u_cls (
         .op_i (insn_a[s][OP_LSB +: OP_W]),
         .cls_o(cls_a[s])
      );
   end

   hzd_src_dec u_src (
      .cls_i(cls_a[0]),
      .re1_o(re1_d),
      .re2_o(re2_d)
   );

   for (genvar s = 1; s < NST; s++) begin : g_later
      logic              we_s;
      logic [REG_AW-1:0] ws_s;

      hzd_dest_dec #(.REG_AW(REG_AW), .LINK_REG(LINK_REG)) u_dst (
         .cls_i(cls_a[s]),
         .rt_i (insn_a[s][RT_LSB +: REG_AW]),
         .rd_i (insn_a[s][RD_LSB +: REG_AW]),
         .we_o (we_s),
         .ws_o (ws_s)
      );

      hzd_cmp #(.REG_AW(REG_AW)) u_cmp_rs (
         .src_i(insn_a[0][RS_LSB +: REG_AW]),
         .re_i (re1_d),
         .ws_i (ws_s),
         .we_i (we_s),
         .hit_o(hit_rs[s-1])
      );

      hzd_cmp #(.REG_AW(REG_AW)) u_cmp_rt (
         .src_i(insn_a[0][RT_LSB +: REG_AW]),
         .re_i (re2_d),
         .ws_i (ws_s),
         .we_i (we_s),
         .hit_o(hit_rt[s-1])
      );
   end

   assign stall = (|hit_rs) || (|hit_rt);
endmodule

// File: rtl/hazard_interlock_chk.sv
module hazard_interlock_chk #(
   parameter int INSN_W   = 32,
   parameter int OP_W     = 6,
   parameter int REG_AW   = 5,
   parameter int LINK_REG = 31,
   parameter logic [OP_W-1:0] OP_RTYPE   = 6'h00,
   parameter logic [OP_W-1:0] OP_JUMP    = 6'h02,
   parameter logic [OP_W-1:0] OP_JLINK   = 6'h03,
   parameter logic [OP_W-1:0] OP_JLREG   = 6'h07,
   parameter logic [OP_W-1:0] OP_ALUI_LO = 6'h08,
   parameter logic [OP_W-1:0] OP_ALUI_HI = 6'h0F,
   parameter logic [OP_W-1:0] OP_LOAD    = 6'h23
) (
   input logic [INSN_W-1:0] insn_d,
   input logic [INSN_W-1:0] insn_e,
   input logic [INSN_W-1:0] insn_m,
   input logic [INSN_W-1:0] insn_w,
   input logic              stall
);
   localparam int OP_LSB = INSN_W - OP_W;
   localparam int RS_LSB = OP_LSB - REG_AW;
   localparam int RT_LSB = RS_LSB - REG_AW;

   function automatic logic may_write(input logic [INSN_W-1:0] w);
      logic [OP_W-1:0] o;
      o = w[OP_LSB +: OP_W];
      return (o == OP_RTYPE) || (o == OP_LOAD) || (o == OP_JLINK) ||
             (o == OP_JLREG) || (o >= OP_ALUI_LO && o <= OP_ALUI_HI);
   endfunction

   logic [OP_W-1:0]   op_d, op_e;
   logic [REG_AW-1:0] rs_d, rt_d;

   always_comb begin
      op_d = insn_d[OP_LSB +: OP_W];
      op_e = insn_e[OP_LSB +: OP_W];
      rs_d = insn_d[RS_LSB +: REG_AW];
      rt_d = insn_d[RT_LSB +: REG_AW];

      p_bubble_quiet_r8: assert (!((insn_e == '0) && (insn_m == '0) && (insn_w == '0)) || !stall)
         else $error("stall with only bubbles downstream");
      p_jump_reads_none_r6: assert (!((op_d == OP_JUMP) || (op_d == OP_JLINK)) || !stall)
         else $error("stall raised for a jump in decode");
      p_no_writer_r5: assert (may_write(insn_e) || may_write(insn_m) || may_write(insn_w) || !stall)
         else $error("stall with no register writer downstream");
      p_link_dest_r3: assert (!((op_e == OP_JLINK) && (op_d == OP_RTYPE) &&
                                (rs_d == REG_AW'(LINK_REG))) || stall)
         else $error("link register write in execute not seen");
      p_reg_zero_r4: assert (!((rs_d == '0) && (rt_d == '0)) || !stall)
         else $error("stall on register zero sources");
   end
endmodule

bind hazard_interlock hazard_interlock_chk #(
   .INSN_W(INSN_W), .OP_W(OP_W), .REG_AW(REG_AW), .LINK_REG(LINK_REG),
   .OP_RTYPE(OP_RTYPE), .OP_JUMP(OP_JUMP), .OP_JLINK(OP_JLINK), .OP_JLREG(OP_JLREG),
   .OP_ALUI_LO(OP_ALUI_LO), .OP_ALUI_HI(OP_ALUI_HI), .OP_LOAD(OP_LOAD)
) u_chk (
   .insn_d(insn_d),
   .insn_e(insn_e),
   .insn_m(insn_m),
   .insn_w(insn_w),
   .stall (stall)
);

// File: tb/sim_hazard_interlock.sv
module sim_hazard_interlock;
   localparam logic [5:0] RT = 6'h00, JP = 6'h02, JL = 6'h03, BZ = 6'h04, JR = 6'h06,
                          JLR = 6'h07, AI = 6'h08, AI2 = 6'h0C, LD = 6'h23, ST = 6'h2B,
                          BAD = 6'h3F;

   function automatic logic [31:0] rr(input int s, input int t, input int d);
      return {RT, 5'(s), 5'(t), 5'(d), 11'h020};
   endfunction
   function automatic logic [31:0] it(input logic [5:0] o, input int s, input int t);
      return {o, 5'(s), 5'(t), 16'h1234};
   endfunction

   typedef struct packed {
      logic [31:0] d, e, m, w;
      logic        exp;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VECS [NV] = '{
      {32'h0, 32'h0, 32'h0, 32'h0, 1'b0, 8'd8},                                 // R8 all bubbles
      {rr(1,2,3), rr(0,0,1), 32'h0, 32'h0, 1'b1, 8'd1},                         // R1 rs vs E rd
      {rr(5,2,3), 32'h0, it(AI,0,5), 32'h0, 1'b1, 8'd3},                        // R3 ALUI dest rt in M
      {rr(7,9,3), 32'h0, 32'h0, it(LD,1,9), 1'b1, 8'd2},                        // R2 rt vs load dest in W
      {it(AI,4,9), it(LD,1,9), 32'h0, 32'h0, 1'b0, 8'd7},                       // R7 ALUI rt not read
      {rr(31,0,3), {JL,26'h0}, 32'h0, 32'h0, 1'b1, 8'd3},                       // R3 JAL writes 31
      {rr(31,0,3), 32'h0, it(JLR,2,0), 32'h0, 1'b1, 8'd3},                      // R3 JALR writes 31
      {rr(0,0,3), rr(0,0,0), it(AI2,0,0), 32'h0, 1'b0, 8'd4},                   // R4 writes to r0
      {it(ST,3,6), rr(1,1,6), 32'h0, 32'h0, 1'b1, 8'd2},                        // R2 store reads rt
      {it(LD,2,8), it(ST,2,8), 32'h0, 32'h0, 1'b0, 8'd5},                       // R5 store then load
      {{JP,5'd5,5'd5,16'h0}, rr(0,0,5), 32'h0, 32'h0, 1'b0, 8'd6},              // R6 jump reads none
      {{JL,5'd5,5'd5,16'h0}, 32'h0, rr(0,0,5), 32'h0, 1'b0, 8'd6},              // R6 JAL reads none
      {it(BZ,5,7), rr(0,0,7), 32'h0, 32'h0, 1'b0, 8'd7},                        // R7 branch rt not read
      {it(BZ,5,7), rr(0,0,5), 32'h0, 32'h0, 1'b1, 8'd1},                        // R1 branch reads rs
      {it(JR,4,0), 32'h0, 32'h0, it(AI,0,4), 1'b1, 8'd1},                       // R1 JR reads rs
      {rr(3,4,5), it(BZ,3,3), {JP,26'h3FFFFFF}, {BAD,5'd3,5'd3,5'd3,11'h0}, 1'b0, 8'd5}, // R5
      {rr(3,4,5), rr(3,3,5), 32'h0, 32'h0, 1'b0, 8'd1},                         // R1 dest not read
      {rr(3,4,5), {JL,5'd3,5'd4,16'h0}, 32'h0, 32'h0, 1'b0, 8'd3},              // R3 JAL fields ignored
      {it(ST,0,0), it(ST,0,0), it(JR,0,0), it(BZ,1,1), 1'b0, 8'd5},             // R5 non-writers
      {rr(0,0,0), 32'h0, 32'h0, 32'h0, 1'b0, 8'd8}                              // R8 bubble in decode
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] insn_d = '0, insn_e = '0, insn_m = '0, insn_w = '0;
   logic        stall;
   int          n_chk = 0;
   int          n_fail = 0;
   bit          done = 0;

   always #10 clk = ~clk;

   hazard_interlock u0 (
      .insn_d(insn_d), .insn_e(insn_e), .insn_m(insn_m), .insn_w(insn_w), .stall(stall)
   );

   function automatic void dst(input logic [31:0] x, output logic we, output logic [4:0] ws);
      logic [5:0] o;
      o = x[31:26];
      we = 1'b0;
      ws = 5'd0;
      if (o == RT) ws = x[15:11];
      else if ((o >= AI && o <= 6'h0F) || o == LD) ws = x[20:16];
      if (o == JL || o == JLR) begin ws = 5'd31; we = 1'b1; end
      else if (o == RT || (o >= AI && o <= 6'h0F) || o == LD) we = (ws != 0);
   endfunction

   function automatic logic ref_stall(input logic [31:0] d, e, m, w);
      logic [5:0]  o;
      logic        r1, r2, we, res;
      logic [4:0]  ws;
      logic [31:0] lst [3];
      o = d[31:26];
      r1 = (o == RT) || (o >= AI && o <= 6'h0F) || o == LD || o == ST || o == BZ ||
           o == JR || o == JLR;
      r2 = (o == RT) || (o == ST);
      lst[0] = e; lst[1] = m; lst[2] = w;
      res = 1'b0;
      for (int k = 0; k < 3; k++) begin
         dst(lst[k], we, ws);
         if (we && ((r1 && d[25:21] == ws) || (r2 && d[20:16] == ws))) res = 1'b1;
      end
      return res;
   endfunction

   task automatic check(input logic exp, input string req);
      n_chk++;
      if (stall !== exp) begin
         n_fail++;
         $display("FAIL %s: stall=%b expected %b (d=%h e=%h m=%h w=%h)",
                  req, stall, exp, insn_d, insn_e, insn_m, insn_w);
      end
   endtask

   task automatic apply(input logic [31:0] d, e, m, w);
      @(posedge clk);
      #1;
      insn_d = d; insn_e = e; insn_m = m; insn_w = w;
      @(negedge clk);
   endtask

   function automatic logic [31:0] rnd_insn();
      logic [5:0] ops [12];
      logic [4:0] f [3];
      ops = '{RT, RT, JP, JL, BZ, JR, JLR, AI, AI2, LD, ST, BAD};
      for (int k = 0; k < 3; k++) f[k] = ($urandom % 5 == 4) ? 5'd31 : 5'($urandom % 4);
      return {ops[$urandom % 12], f[0], f[1], f[2], 11'($urandom)};
   endfunction

   initial begin
      repeat (3) @(posedge clk);
      rst = 1'b0;
      @(negedge clk);
      check(1'b0, "R8 reset state, all-zero words");

      for (int i = 0; i < NV; i++) begin
         apply(VECS[i].d, VECS[i].e, VECS[i].m, VECS[i].w);
         check(VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i));
      end

      // R1 R2 R3 R4 R5 R6 R7: random quadruples against the requirement model
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] a, b, c, g;
         a = rnd_insn(); b = rnd_insn(); c = rnd_insn(); g = rnd_insn();
         apply(a, b, c, g);
         check(ref_stall(a, b, c, g), "R1/R2 random quadruple");
      end

      // R4 corner: load to r0 in each later stage, decode reads r0 twice
      apply(rr(0,0,9), it(LD,3,0), it(LD,3,0), it(LD,3,0));
      check(1'b0, "R4 load to r0");
      // R3 corner: JALR in W, store reads r31 as data source
      apply(it(ST,2,31), 32'h0, 32'h0, it(JLR,0,0));
      check(1'b1, "R3 JALR link vs store rt");

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule